// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Encoding and Expiry Actions

The block is a register-mapped watchdog that counts down from a one-millisecond tick input and must be restarted by software before it runs out. A byte-wide register bus programs the timeout, the expiry action and the enable, and a write to the ping address restarts the countdown. An elaboration parameter selects one of three variants. Variant 0 takes a 4-bit exponent n and times out after 2^n ms. Variant 1 takes an 8-bit count of whole seconds. Variant 2 takes a 16-bit count of whole seconds. The two seconds variants report the seconds remaining.

On expiry the block takes the programmed action. It can pulse a system reset, raise a fan full-speed request, or bump a saturating expiry counter. The two non-reset actions reload the timer, which keeps running. A lock bit stops software from disabling a running watchdog. A cause flag records that the watchdog produced the last reset, and the block's own configuration clear on that reset leaves the flag alone.

Register map (3-bit address): 0 control, 1 timeout low byte, 2 timeout high byte, 3 ping, 4 time-left low byte, 5 time-left high byte, 6 expiry count, 7 status.

Top module: `guard_timer`

## Requirements
- R1: In variant 0, timeout[3:0] holds an exponent n. After a reload, the expiry takes effect on exactly the 2^n-th tick, so n=15 gives 32768 ticks. Bits above [3:0] are not stored. Both time-left bytes read 0.
- R2: In variants 1 and 2 the timeout is a count of whole seconds. Variant 1 uses 8 bits at address 1 and ignores address 2. Variant 2 uses 16 bits, little-endian, low byte at address 1 and high byte at address 2. Expiry falls on the tick that completes value × TICKS_PER_SEC ticks after a reload. A value of 0 acts as 1.
- R3: In variants 1 and 2, time-left (address 4 low, address 5 high) reads the full value right after a reload. It drops by one after every TICKS_PER_SEC ticks.
- R4: A write of any data to address 3 reloads the full timeout and restarts the sub-second count, so an expiry that was pending is pushed back.
- R5: Control bit 0 is the enable. A 0-to-1 write loads the timer. While the enable is 0, ticks change neither time-left nor any action output.
- R6: Control bit 1 is the lock. Once set it reads 1. While it and the enable are both set, control writes cannot clear either bit. Only reset or a reset-action expiry clears the lock.
- R7: Control bits [3:2] select the action: 01 fan, 10 count, 00 or 11 reset. On a reset expiry, sys_rst_o goes high in the cycle after the expiring tick edge and stays high for exactly RST_HOLD (16) cycles. The control and timeout registers then read 0.
- R8: Status bit 0 (address 7) is the reset-cause flag. A reset expiry sets it, and it survives the configuration clear of R7. Writing 1 to status bit 0 clears it.
- R9: On a fan expiry, fan_full_o and status bit 1 go high and stay high, and the timer reloads and keeps counting. Writing 1 to status bit 1 clears them.
- R10: On a count expiry, the expiry count at address 6 rises by one, saturates at 255 and reloads the timer. sys_rst_o stays low.
- R11: After reset, all eight addresses read 0 and both action outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tick_ms | input | 1 | One-cycle millisecond tick |
| sys_rst_o | output | 1 | System reset request pulse |
| fan_full_o | output | 1 | Fan full-speed request |

## Verification
A register write takes effect at the clock edge that captures it. Read data follows the address within the same cycle. The bench drives each write for one cycle from the falling edge and samples reads half a cycle after it sets the address. Every expiry effect (expiry count, fan request, cause flag, reload, start of the reset pulse) shows up right after the edge that captures the final tick, so the bench checks these at the falling edge that ends its tick burst. The reset pulse is counted in falling-edge samples and must total exactly 16.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  typedef enum logic [1:0] {
    ACT_RESET  = 2'b00,
    ACT_FAN    = 2'b01,
    ACT_COUNT  = 2'b10,
    ACT_RESET2 = 2'b11
  } act_e;

  typedef struct packed {
    act_e act;
    logic lock;
    logic en;
  } ctrl_t;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_TLO   = 3'd1;
  localparam logic [2:0] ADR_THI   = 3'd2;
  localparam logic [2:0] ADR_PING  = 3'd3;
  localparam logic [2:0] ADR_LLO   = 3'd4;
  localparam logic [2:0] ADR_LHI   = 3'd5;
  localparam logic [2:0] ADR_EVT   = 3'd6;
  localparam logic [2:0] ADR_STAT  = 3'd7;

endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import guard_timer_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        soft_clr,
  input  logic [15:0] left,
  input  logic [7:0]  evcnt,
  input  logic        cause,
  input  logic        fan,
  output ctrl_t       ctrl,
  output logic [TW-1:0] tout,
  output logic        load_req,
  output logic        cause_clr,
  output logic        fan_clr,
  output logic [7:0]  rdata
);

  localparam logic [15:0] TMASK = 16'((32'd1 << TW) - 32'd1);

  ctrl_t       ctrl_q, ctrl_n;
  logic [15:0] tout_q, tout_n;
  logic        upd;

  assign upd = wr | soft_clr;

  always_comb begin
    ctrl_n = ctrl_q;
    tout_n = tout_q;
    if (soft_clr) begin
      ctrl_n = '0;
      tout_n = '0;
    end else if (wr) begin
      case (addr)
        ADR_CTRL: begin
          ctrl_n.en   = wdata[0] | (ctrl_q.lock & ctrl_q.en);
          ctrl_n.lock = wdata[1] | ctrl_q.lock;
          ctrl_n.act  = act_e'(wdata[3:2]);
        end
        ADR_TLO: tout_n = {tout_q[15:8], wdata} & TMASK;
        ADR_THI: tout_n = {wdata, tout_q[7:0]} & TMASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tout_q <= '0;
    end else if (upd) begin
      ctrl_q <= ctrl_n;
      tout_q <= tout_n;
    end
  end

  assign load_req  = wr & ((addr == ADR_PING) |
                           ((addr == ADR_CTRL) & wdata[0] & ~ctrl_q.en));
  assign cause_clr = wr & (addr == ADR_STAT) & wdata[0];
  assign fan_clr   = wr & (addr == ADR_STAT) & wdata[1];

  assign ctrl = ctrl_q;
  assign tout = tout_q[TW-1:0];

  always_comb begin
    case (addr)
      ADR_CTRL: rdata = {4'b0, ctrl_q.act, ctrl_q.lock, ctrl_q.en};
      ADR_TLO:  rdata = tout_q[7:0];
      ADR_THI:  rdata = tout_q[15:8];
      ADR_LLO:  rdata = left[7:0];
      ADR_LHI:  rdata = left[15:8];
      ADR_EVT:  rdata = evcnt;
      ADR_STAT: rdata = {6'b0, fan, cause};
      default:  rdata = 8'h00;
    endcase
  end

  // R6: a locked, running watchdog stays enabled and locked
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.lock && ctrl_q.en && !soft_clr) |=> (ctrl_q.en && ctrl_q.lock));

  // R7: a reset-action expiry leaves configuration cleared
  a_r7_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ctrl_q == '0 && tout_q == '0));

endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CW         = 16,
  parameter int UNIT_TICKS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          load_req,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expire
);

  localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_TICKS - 1);

  logic [PW-1:0] pre_q, pre_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          unit_end, step, upd;

  assign unit_end = (pre_q == PRE_LAST);
  assign step     = en & tick & ~load_req;
  assign upd      = load_req | step;
  assign expire   = step & unit_end & (cnt_q == CW'(1));

  always_comb begin
    pre_n = pre_q;
    cnt_n = cnt_q;
    if (load_req) begin
      pre_n = '0;
      cnt_n = load_val;
    end else if (step) begin
      if (unit_end) begin
        pre_n = '0;
        cnt_n = (cnt_q == CW'(1)) ? load_val : cnt_q - CW'(1);
      end else begin
        pre_n = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      pre_q <= pre_n;
      cnt_q <= cnt_n;
    end
  end

  assign cnt = cnt_q;

  // R2: an enabled timer never holds a zero count (zero timeout acts as one)
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q != '0));

  // R5: with the enable low and no load, the count does not move
  a_r5_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_req) |=> $stable(cnt_q));

endmodule

// File: rtl/gt_actions.sv
module gt_actions
  import guard_timer_pkg::*;
#(
  parameter int RST_HOLD = 16,
  parameter int EVW      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           expire,
  input  act_e           act,
  input  logic           fan_clr,
  input  logic           cause_clr,
  output logic           soft_clr,
  output logic           sys_rst,
  output logic           fan,
  output logic           cause,
  output logic [EVW-1:0] evcnt
);

  localparam int RCW = $clog2(RST_HOLD + 1);
  localparam logic [EVW-1:0] EV_MAX = '1;

  logic [RCW-1:0] rcnt_q, rcnt_n;
  logic [EVW-1:0] ev_q, ev_n;
  logic           fan_q, fan_n, cause_q, cause_n;
  logic           is_rst, is_fan, is_cnt;

  assign is_rst = expire & ((act == ACT_RESET) | (act == ACT_RESET2));
  assign is_fan = expire & (act == ACT_FAN);
  assign is_cnt = expire & (act == ACT_COUNT);

  always_comb begin
    rcnt_n  = (rcnt_q != '0) ? rcnt_q - RCW'(1) : '0;
    if (is_rst) rcnt_n = RCW'(RST_HOLD);
    ev_n    = (is_cnt && ev_q != EV_MAX) ? ev_q + EVW'(1) : ev_q;
    fan_n   = is_fan | (fan_q & ~fan_clr);
    cause_n = is_rst | (cause_q & ~cause_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q  <= '0;
      ev_q    <= '0;
      fan_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      rcnt_q  <= rcnt_n;
      if (is_cnt) ev_q <= ev_n;
      fan_q   <= fan_n;
      cause_q <= cause_n;
    end
  end

  assign soft_clr = is_rst;
  assign sys_rst  = (rcnt_q != '0);
  assign fan      = fan_q;
  assign cause    = cause_q;
  assign evcnt    = ev_q;

  // R7: the reset pulse only starts after an expiry
  a_r7_pulse_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(expire));

  // R10: the expiry count saturates
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q == EV_MAX) |=> (ev_q == EV_MAX));

  // R9: the fan request only drops on a software clear
  a_r9_fan_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fan_q) |-> $past(fan_clr));

  // R8: the cause flag only drops on a software clear
  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cause_q) |-> $past(cause_clr));

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int VARIANT       = 2,
  parameter int TICKS_PER_SEC = 1000,
  parameter int RST_HOLD      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_ms,
  output logic       sys_rst_o,
  output logic       fan_full_o
);

  localparam int TW         = (VARIANT == 0) ? 4 : ((VARIANT == 1) ? 8 : 16);
  localparam int CW         = (VARIANT == 1) ? 8 : 16;
  localparam int UNIT_TICKS = (VARIANT == 0) ? 1 : TICKS_PER_SEC;

  logic [1:0]    rst_sync;
  logic          rst_ns;
  ctrl_t         ctrl;
  logic [TW-1:0] tout;
  logic [CW-1:0] load_val, cnt;
  logic [15:0]   left;
  logic [7:0]    evcnt;
  logic          load_req, cause_clr, fan_clr, soft_clr;
  logic          expire, cause, fan, sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  generate
    if (VARIANT == 0) begin : g_pow2
      assign load_val = CW'(1) << tout;
      assign left     = 16'h0000;
    end else begin : g_secs
      assign load_val = (tout == '0) ? CW'(1) : CW'(tout);
      assign left     = 16'(cnt);
    end
  endgenerate

  gt_regs #(.TW(TW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .soft_clr  (soft_clr),
    .left      (left),
    .evcnt     (evcnt),
    .cause     (cause),
    .fan       (fan),
    .ctrl      (ctrl),
    .tout      (tout),
    .load_req  (load_req),
    .cause_clr (cause_clr),
    .fan_clr   (fan_clr),
    .rdata     (bus_rdata)
  );

  gt_counter #(.CW(CW), .UNIT_TICKS(UNIT_TICKS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .en       (ctrl.en),
    .tick     (tick_ms),
    .load_req (load_req),
    .load_val (load_val),
    .cnt      (cnt),
    .expire   (expire)
  );

  gt_actions #(.RST_HOLD(RST_HOLD), .EVW(8)) u_act (
    .clk       (clk),
    .rst_n     (rst_ns),
    .expire    (expire),
    .act       (ctrl.act),
    .fan_clr   (fan_clr),
    .cause_clr (cause_clr),
    .soft_clr  (soft_clr),
    .sys_rst   (sys_rst),
    .fan       (fan),
    .cause     (cause),
    .evcnt     (evcnt)
  );

  assign sys_rst_o  = sys_rst;
  assign fan_full_o = fan;

  // R1: the power-of-two variant reports no time left
  a_r1_no_left: assert property (@(posedge clk) disable iff (!rst_ns)
    (VARIANT == 0) |-> (left == 16'h0000));

endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;

  localparam int TPS = 4;

  logic       clk, rst_n, tick;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic       wr_a, wr_b, wr_c;
  logic [7:0] rd_a, rd_b, rd_c;
  logic       srst_a, srst_b, srst_c, fan_a, fan_b, fan_c;
  int total, bad;
  bit done;

  // uut: 16-bit seconds, uut_s8: 8-bit seconds, uut_p2: power-of-two ms
  guard_timer #(.VARIANT(2), .TICKS_PER_SEC(TPS), .RST_HOLD(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_a), .tick_ms(tick), .sys_rst_o(srst_a), .fan_full_o(fan_a));
  guard_timer #(.VARIANT(1), .TICKS_PER_SEC(TPS), .RST_HOLD(16)) uut_s8 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_b), .tick_ms(tick), .sys_rst_o(srst_b), .fan_full_o(fan_b));
  guard_timer #(.VARIANT(0), .TICKS_PER_SEC(TPS), .RST_HOLD(16)) uut_p2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_c), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_c), .tick_ms(tick), .sys_rst_o(srst_c), .fan_full_o(fan_c));

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic int exp_left(int t, int k);
    return t - (k / TPS);
  endfunction

  function automatic int exp_p2_ticks(int n);
    return 1 << n;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int which, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (which == 0) wr_a = 1'b1;
    else if (which == 1) wr_b = 1'b1;
    else wr_c = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
  endtask

  task automatic rd(int which, logic [2:0] a, output int d);
    addr = a;
    #1;
    d = (which == 0) ? int'(rd_a) : ((which == 1) ? int'(rd_b) : int'(rd_c));
  endtask

  task automatic ticks(int k);
    if (k > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (k) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, e, t, k, n, hi;
    total = 0; bad = 0; done = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick = 1'b0; addr = '0; wdata = '0;
    wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 8; a++) begin
      rd(0, 3'(a), v); chk("R11 uut reg", v, 0);
      rd(1, 3'(a), v); chk("R11 s8 reg", v, 0);
      rd(2, 3'(a), v); chk("R11 p2 reg", v, 0);
    end
    chk("R11 outputs", int'(srst_a | srst_b | srst_c | fan_a | fan_b | fan_c), 0);

    // R2 R3 R10: 3 s timeout with count action
    wr(0, 3'd1, 8'd3);
    wr(0, 3'd0, 8'h09);
    rd(0, 3'd4, v); chk("R3 left after enable", v, 3);
    ticks(4);  rd(0, 3'd4, v); chk("R3 left after 1 s", v, exp_left(3, 4));
    ticks(7);  rd(0, 3'd6, v); chk("R2 no expiry before 12 ticks", v, 0);
    ticks(1);  rd(0, 3'd6, v); chk("R10 count after expiry", v, 1);
    rd(0, 3'd4, v); chk("R10 reload after expiry", v, 3);
    chk("R10 no reset pulse", int'(srst_a), 0);

    // R2 R3: little-endian 16-bit timeout of 300 s
    wr(0, 3'd1, 8'h2C);
    wr(0, 3'd2, 8'h01);
    wr(0, 3'd3, 8'h00);
    rd(0, 3'd4, v); chk("R3 left low byte", v, 8'h2C);
    rd(0, 3'd5, v); chk("R3 left high byte", v, 8'h01);
    wr(0, 3'd2, 8'h00);

    // R4: ping pushes back an expiry
    wr(0, 3'd1, 8'd2);
    wr(0, 3'd3, 8'hA5);
    ticks(6);
    wr(0, 3'd3, 8'h00);
    rd(0, 3'd4, v); chk("R4 ping reloads", v, 2);
    ticks(7);  rd(0, 3'd6, v); chk("R4 expiry pushed back", v, 1);
    ticks(1);  rd(0, 3'd6, v); chk("R4 expiry after full timeout", v, 2);

    // R2: zero timeout acts as one second
    wr(0, 3'd1, 8'd0);
    wr(0, 3'd3, 8'h00);
    rd(0, 3'd4, v); chk("R2 zero clamps to one", v, 1);
    ticks(3);  rd(0, 3'd6, v); chk("R2 clamp no early expiry", v, 2);
    ticks(1);  rd(0, 3'd6, v); chk("R2 clamp expiry", v, 3);

    // R3 R4: random timeouts and partial waits
    for (int i = 0; i < 20; i++) begin
      t = $urandom_range(1, 5);
      k = $urandom_range(0, t * TPS - 1);
      wr(0, 3'd1, 8'(t));
      wr(0, 3'd3, 8'h00);
      ticks(k);
      rd(0, 3'd4, v); chk("R3 random left", v, exp_left(t, k));
    end
    rd(0, 3'd6, v); chk("R4 random no expiry", v, 3);

    // R5: disabled timer ignores ticks
    wr(0, 3'd1, 8'd1);
    wr(0, 3'd3, 8'h00);
    wr(0, 3'd0, 8'h08);
    rd(0, 3'd0, v); chk("R5 enable cleared", v, 8'h08);
    ticks(20);
    rd(0, 3'd6, v); chk("R5 no expiry while disabled", v, 3);
    rd(0, 3'd4, v); chk("R5 left frozen", v, 1);

    // R6: lock keeps the enable
    wr(0, 3'd0, 8'h0B);
    wr(0, 3'd0, 8'h08);
    rd(0, 3'd0, v); chk("R6 lock blocks disable", v, 8'h0B);

    // R7 R8: reset action
    wr(0, 3'd0, 8'h03);
    wr(0, 3'd3, 8'h00);
    ticks(3);
    chk("R7 no pulse before expiry", int'(srst_a), 0);
    ticks(1);
    n = 0;
    while (srst_a && n < 40) begin
      n++;
      @(negedge clk);
    end
    chk("R7 pulse length", n, 16);
    rd(0, 3'd0, v); chk("R7 control cleared", v, 0);
    rd(0, 3'd1, v); chk("R7 timeout cleared", v, 0);
    rd(0, 3'd7, v); chk("R8 cause set", v, 1);
    rd(0, 3'd6, v); chk("R7 count untouched", v, 3);
    wr(0, 3'd7, 8'h01);
    rd(0, 3'd7, v); chk("R8 cause cleared", v, 0);

    // R2 R9: 8-bit seconds variant with fan action
    wr(1, 3'd2, 8'h05);
    rd(1, 3'd2, v); chk("R2 s8 high byte ignored", v, 0);
    wr(1, 3'd1, 8'd2);
    wr(1, 3'd0, 8'h05);
    ticks(7);  chk("R9 fan low before expiry", int'(fan_b), 0);
    ticks(1);  chk("R9 fan set", int'(fan_b), 1);
    rd(1, 3'd7, v); chk("R9 status fan bit", v, 2);
    rd(1, 3'd4, v); chk("R9 reload after fan", v, 2);
    ticks(8);  chk("R9 fan stays", int'(fan_b), 1);
    chk("R9 no reset pulse", int'(srst_b), 0);
    wr(1, 3'd7, 8'h02);
    chk("R9 fan cleared", int'(fan_b), 0);
    wr(1, 3'd0, 8'h04);

    // R1: power-of-two variant
    wr(2, 3'd1, 8'd3);
    wr(2, 3'd0, 8'h09);
    rd(2, 3'd4, v); chk("R1 left reads zero", v, 0);
    ticks(7);  rd(2, 3'd6, v); chk("R1 no expiry before 8", v, 0);
    ticks(1);  rd(2, 3'd6, v); chk("R1 expiry at 8", v, 1);
    e = 1;
    for (int i = 0; i < 6; i++) begin
      n = $urandom_range(0, 6);
      k = $urandom_range(0, exp_p2_ticks(n) - 1);
      wr(2, 3'd1, 8'(n));
      wr(2, 3'd3, 8'h00);
      ticks(k);
      rd(2, 3'd6, v); chk("R1 random no early expiry", v, e);
      ticks(exp_p2_ticks(n) - k);
      e++;
      rd(2, 3'd6, v); chk("R1 random expiry", v, e);
    end
    wr(2, 3'd1, 8'hFF);
    rd(2, 3'd1, v); chk("R1 exponent field width", v, 8'h0F);
    wr(2, 3'd3, 8'h00);
    ticks(32767); rd(2, 3'd6, v); chk("R1 max no early expiry", v, e);
    ticks(1);     rd(2, 3'd6, v); chk("R1 max expiry at 32768", v, e + 1);
    rd(2, 3'd5, hi); chk("R1 left high zero", hi, 0);

    // R10: saturation with one-tick timeout
    wr(2, 3'd1, 8'd0);
    wr(2, 3'd3, 8'h00);
    ticks(300);
    rd(2, 3'd6, v); chk("R10 saturates at 255", v, 255);
    chk("R10 no reset pulse p2", int'(srst_c), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule